// File: doc/BRIEF.md
# Unified Four-Way Write-Back Cache

This block is one cache that serves both instruction fetches and data loads and stores. It sits between a processor request port and a word-addressed external memory port. Because both streams use the same storage and the same request port, a word that was just stored comes back on the next fetch of that address. No barrier and no invalidate are needed for that. The cache is four-way set associative. The set is chosen by the low nine address bits, so addresses 512 words apart compete for the same set. Each line holds one word.

Stores that hit only mark the line dirty. A dirty line reaches memory in two cases: when the least-recently-used replacement evicts it, or when a flush command walks the arrays. A flush-all command writes back and invalidates every line. A flush-page command does the same only for lines whose tag equals a given 512-word page number. A request can also be marked uncached. Such a request still returns what a cached request would return: a hit is served from the cache, and a miss goes straight to memory without allocating a line. The cache does not observe memory traffic from other masters.

Top module: `unified_cache`

## Requirements
- R1: A read returns the memory word on a miss and the resident word on a hit. Operation code 0 on `reqOp` is read, and each accepted read gives one `rspValid` pulse carrying the data on `rspRdata`.
- R2: After a write (operation code 1) to an address, the next read of that address returns the written word. Fetches and data reads use the same request port and the same storage.
- R3: A write that hits a resident line issues no memory write.
- R4: Four different addresses whose low nine bits match can be resident at the same time. Reading any of them again returns the cached word even after memory has been changed behind the cache.
- R5: On a miss in a full set, the least-recently-used way is replaced. A dirty victim is written to memory before the line is reused.
- R6: A request with `reqUncached` high returns the same data as a cached request. An uncached read hit returns the resident word. An uncached miss reads or writes memory directly and allocates no line.
- R7: Flush-all (operation code 2) writes every dirty line back, invalidates every line, and ends with exactly one `flushDone` pulse.
- R8: Flush-page (operation code 3) takes its page number from `reqAddr[13:9]`. It writes back and invalidates only the lines whose tag equals that page number and leaves every other line resident.
- R9: Memory changes made by another master are not returned while the affected line is resident.
- R10: `reqReady` is high only when the block is idle. A flush produces no `rspValid`, and no memory request is made while `reqReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle; a request is accepted when valid and ready are both high |
| reqOp | input | 2 | 0 read, 1 write, 2 flush-all, 3 flush-page |
| reqUncached | input | 1 | Bypass allocation for this access |
| reqAddr | input | 14 | Word address; bits 13:9 give the page for flush-page |
| reqWdata | input | 32 | Store data |
| rspValid | output | 1 | One-cycle response for a read or write |
| rspRdata | output | 32 | Read data |
| flushDone | output | 1 | One-cycle pulse at the end of a flush |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWe | output | 1 | Memory write when high, read when low |
| memAddr | output | 14 | Memory word address |
| memWdata | output | 32 | Memory write data |
| memAck | input | 1 | One-cycle acknowledge; read data valid with it |
| memRdata | input | 32 | Memory read data |

## Verification
Requests are accepted on a rising edge. A cached hit raises `rspValid` in the second cycle after that edge. A miss adds one memory handshake for a refill or an uncached access, and one more for a dirty victim. A flush needs one cycle per set plus one handshake per dirty line before `flushDone` rises. The bench therefore samples at falling edges. It waits for `rspValid` or `flushDone` under a timeout rather than counting cycles, and it reads the memory model's contents only after that response has arrived.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {OP_READ, OP_WRITE, OP_FLALL, OP_FLPAGE} op_e;
  typedef enum logic [1:0] {MS_DIRECT, MS_VICTIM, MS_FLUSH} memsel_e;

  typedef struct packed {
    logic    latch;
    logic    install;
    logic    hitWrite;
    logic    touchHit;
    logic    touchVictim;
    logic    flWbClear;
    logic    flClear;
    logic    scanReset;
    logic    scanStep;
    logic    rspLoad;
    logic    rspFromMem;
    memsel_e memSel;
  } strobe_t;
endpackage

// File: rtl/unified_cache_dp.sv
module unified_cache_dp
  import cache_pkg::*;
#(
  parameter int ADDR_W  = 14,
  parameter int DATA_W  = 32,
  parameter int WAYS    = 4,
  parameter int INDEX_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [1:0]        reqOp,
  input  logic              reqUncached,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memRdata,
  output op_e               rqOp,
  output logic              rqUnc,
  output logic              hit,
  output logic              victimDirty,
  output logic              flDirtyAny,
  output logic              scanLast,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata
);
  localparam int TAG_W = ADDR_W - INDEX_W;
  localparam int SETS  = 1 << INDEX_W;
  localparam int WAY_W = $clog2(WAYS);

  logic [TAG_W-1:0]  tagMem   [SETS][WAYS];
  logic [DATA_W-1:0] dataMem  [SETS][WAYS];
  logic [WAY_W-1:0]  ageMem   [SETS][WAYS];
  logic [WAYS-1:0]   validMem [SETS];
  logic [WAYS-1:0]   dirtyMem [SETS];

  logic [ADDR_W-1:0]  rqAddr;
  logic [DATA_W-1:0]  rqWdata;
  logic [INDEX_W-1:0] scanIdx;

  wire [INDEX_W-1:0] idx = rqAddr[INDEX_W-1:0];
  wire [TAG_W-1:0]   tag = rqAddr[ADDR_W-1:INDEX_W];

  logic [WAYS-1:0]  hitMask, selMask, flDirtyMask;
  logic [WAY_W-1:0] hitWay, victimWay, flWay, touchWay;
  logic             anyFree;

  always_comb begin
    hitWay    = '0;
    victimWay = '0;
    flWay     = '0;
    anyFree   = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      hitMask[w] = validMem[idx][w] && (tagMem[idx][w] == tag);
      selMask[w] = validMem[scanIdx][w] &&
                   (rqOp == OP_FLALL || tagMem[scanIdx][w] == tag);
      flDirtyMask[w] = selMask[w] && dirtyMem[scanIdx][w];
      if (hitMask[w]) hitWay = WAY_W'(w);
      if (flDirtyMask[w]) flWay = WAY_W'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--)
      if (ageMem[idx][w] == WAY_W'(WAYS - 1)) victimWay = WAY_W'(w);
    for (int w = WAYS - 1; w >= 0; w--)
      if (!validMem[idx][w]) begin
        victimWay = WAY_W'(w);
        anyFree   = 1'b1;
      end
  end

  assign hit         = |hitMask;
  assign victimDirty = !anyFree && dirtyMem[idx][victimWay];
  assign flDirtyAny  = |flDirtyMask;
  assign scanLast    = scanIdx == INDEX_W'(SETS - 1);
  assign touchWay    = stb.touchHit ? hitWay : victimWay;

  always_comb begin
    unique case (stb.memSel)
      MS_VICTIM: begin
        memAddr  = {tagMem[idx][victimWay], idx};
        memWdata = dataMem[idx][victimWay];
        memWe    = 1'b1;
      end
      MS_FLUSH: begin
        memAddr  = {tagMem[scanIdx][flWay], scanIdx};
        memWdata = dataMem[scanIdx][flWay];
        memWe    = 1'b1;
      end
      default: begin
        memAddr  = rqAddr;
        memWdata = rqWdata;
        memWe    = rqOp == OP_WRITE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rqOp     <= OP_READ;
      rqUnc    <= 1'b0;
      rqAddr   <= '0;
      rqWdata  <= '0;
      scanIdx  <= '0;
      rspValid <= 1'b0;
      rspRdata <= '0;
      for (int s = 0; s < SETS; s++) begin
        validMem[s] <= '0;
        dirtyMem[s] <= '0;
        for (int w = 0; w < WAYS; w++) ageMem[s][w] <= WAY_W'(w);
      end
    end else begin
      rspValid <= stb.rspLoad;
      if (stb.rspLoad)
        rspRdata <= stb.rspFromMem ? memRdata : dataMem[idx][hitWay];
      if (stb.latch) begin
        rqOp    <= op_e'(reqOp);
        rqUnc   <= reqUncached;
        rqAddr  <= reqAddr;
        rqWdata <= reqWdata;
      end
      if (stb.scanReset) scanIdx <= '0;
      else if (stb.scanStep) scanIdx <= scanIdx + 1'b1;
      if (stb.install) begin
        validMem[idx][victimWay] <= 1'b1;
        dirtyMem[idx][victimWay] <= rqOp == OP_WRITE;
      end
      if (stb.hitWrite) dirtyMem[idx][hitWay] <= 1'b1;
      if (stb.flWbClear) begin
        validMem[scanIdx][flWay] <= 1'b0;
        dirtyMem[scanIdx][flWay] <= 1'b0;
      end
      if (stb.flClear) validMem[scanIdx] <= validMem[scanIdx] & ~selMask;
      if (stb.touchHit || stb.touchVictim)
        for (int w = 0; w < WAYS; w++)
          if (WAY_W'(w) == touchWay) ageMem[idx][w] <= '0;
          else if (ageMem[idx][w] < ageMem[idx][touchWay])
            ageMem[idx][w] <= ageMem[idx][w] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.install) begin
      tagMem[idx][victimWay]  <= tag;
      dataMem[idx][victimWay] <= (rqOp == OP_WRITE) ? rqWdata : memRdata;
    end
    if (stb.hitWrite) dataMem[idx][hitWay] <= rqWdata;
  end
endmodule

// File: rtl/unified_cache_ctl.sv
module unified_cache_ctl
  import cache_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  op_e        rqOp,
  input  logic       rqUnc,
  input  logic       hit,
  input  logic       victimDirty,
  input  logic       flDirtyAny,
  input  logic       scanLast,
  input  logic       memAck,
  output logic       reqReady,
  output logic       memReq,
  output logic       flushDone,
  output strobe_t    stb
);
  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_WB, S_FILL, S_UNC, S_SCAN, S_FLWB} state_e;
  state_e state, nextState;
  wire isWrite = rqOp == OP_WRITE;

  always_comb begin
    stb       = '0;
    nextState = state;
    reqReady  = 1'b0;
    memReq    = 1'b0;
    unique case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.latch = 1'b1;
          if (reqOp[1]) begin
            stb.scanReset = 1'b1;
            nextState     = S_SCAN;
          end else nextState = S_LOOK;
        end
      end
      S_LOOK: begin
        if (hit) begin
          stb.hitWrite = isWrite;
          stb.touchHit = !rqUnc;
          stb.rspLoad  = 1'b1;
          nextState    = S_IDLE;
        end else if (rqUnc) nextState = S_UNC;
        else if (victimDirty) nextState = S_WB;
        else if (isWrite) begin
          stb.install     = 1'b1;
          stb.touchVictim = 1'b1;
          stb.rspLoad     = 1'b1;
          nextState       = S_IDLE;
        end else nextState = S_FILL;
      end
      S_WB: begin
        memReq     = 1'b1;
        stb.memSel = MS_VICTIM;
        if (memAck) begin
          if (isWrite) begin
            stb.install     = 1'b1;
            stb.touchVictim = 1'b1;
            stb.rspLoad     = 1'b1;
            nextState       = S_IDLE;
          end else nextState = S_FILL;
        end
      end
      S_FILL: begin
        memReq = 1'b1;
        if (memAck) begin
          stb.install     = 1'b1;
          stb.touchVictim = 1'b1;
          stb.rspLoad     = 1'b1;
          stb.rspFromMem  = 1'b1;
          nextState       = S_IDLE;
        end
      end
      S_UNC: begin
        memReq = 1'b1;
        if (memAck) begin
          stb.rspLoad    = 1'b1;
          stb.rspFromMem = 1'b1;
          nextState      = S_IDLE;
        end
      end
      S_SCAN: begin
        if (flDirtyAny) nextState = S_FLWB;
        else begin
          stb.flClear = 1'b1;
          if (scanLast) nextState = S_IDLE;
          else stb.scanStep = 1'b1;
        end
      end
      S_FLWB: begin
        memReq     = 1'b1;
        stb.memSel = MS_FLUSH;
        if (memAck) begin
          stb.flWbClear = 1'b1;
          nextState     = S_SCAN;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      flushDone <= 1'b0;
    end else begin
      state     <= nextState;
      flushDone <= state == S_SCAN && !flDirtyAny && scanLast;
    end
  end
endmodule

// File: rtl/unified_cache.sv
module unified_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W  = 14,
  parameter int DATA_W  = 32,
  parameter int WAYS    = 4,
  parameter int INDEX_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic              reqUncached,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              flushDone,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata
);
  strobe_t stb;
  op_e     rqOp;
  logic    rqUnc, hit, victimDirty, flDirtyAny, scanLast;

  unified_cache_ctl u_ctl (
    .clk, .rstN, .reqValid, .reqOp, .rqOp, .rqUnc, .hit, .victimDirty,
    .flDirtyAny, .scanLast, .memAck, .reqReady, .memReq, .flushDone, .stb
  );

  unified_cache_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAYS(WAYS), .INDEX_W(INDEX_W)
  ) u_dp (
    .clk, .rstN, .stb, .reqOp, .reqUncached, .reqAddr, .reqWdata, .memRdata,
    .rqOp, .rqUnc, .hit, .victimDirty, .flDirtyAny, .scanLast, .memWe,
    .memAddr, .memWdata, .rspValid, .rspRdata
  );
endmodule

// File: rtl/unified_cache_chk.sv
module unified_cache_chk #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic              flushDone,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic              memAck
);
  a_r10_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);
  a_r10_idle_no_mem: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memReq);
  a_r1_rsp_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
  a_r1_rsp_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> reqReady);
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    flushDone |=> !flushDone);
  a_r10_done_not_rsp: assert property (@(posedge clk) disable iff (!rstN)
    !(flushDone && rspValid));
  a_r5_mem_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe)
                          && $stable(memWdata));
endmodule

bind unified_cache unified_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk, .rstN, .reqValid, .reqReady, .rspValid, .flushDone, .memReq, .memWe,
  .memAddr, .memWdata, .memAck
);

// File: tb/unified_cache_bench.sv
module unified_cache_bench;
  logic        clk = 1'b0, rstN = 1'b0;
  logic        reqValid = 1'b0, reqUncached = 1'b0;
  logic [1:0]  reqOp = 2'd0;
  logic [13:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        reqReady, rspValid, flushDone, memReq, memWe;
  logic [31:0] rspRdata, memWdata, memRdata;
  logic [13:0] memAddr;
  logic        memAck;

  int checks = 0, errors = 0, memWrites = 0, lat = 0, cycles = 0;
  logic [31:0] memStore [int];

  always #2.5 clk = ~clk;

  unified_cache u_unified_cache (
    .clk, .rstN, .reqValid, .reqReady, .reqOp, .reqUncached, .reqAddr,
    .reqWdata, .rspValid, .rspRdata, .flushDone, .memReq, .memWe, .memAddr,
    .memWdata, .memAck, .memRdata
  );

  function automatic logic [31:0] rdMem(input int a);
    if (memStore.exists(a)) return memStore[a];
    return 32'hA5A50000 | a;
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rstN) begin
      memAck <= 1'b0;
      lat    <= 0;
    end else if (memAck) begin
      memAck <= 1'b0;
      lat    <= 0;
    end else if (memReq) begin
      if (lat == 2) begin
        memAck <= 1'b1;
        if (memWe) begin
          memStore[int'(memAddr)] = memWdata;
          memWrites <= memWrites + 1;
        end else memRdata <= rdMem(int'(memAddr));
      end else lat <= lat + 1;
    end else lat <= 0;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] op, input logic unc, input logic [13:0] a,
                        input logic [31:0] wd, output logic [31:0] rd, output logic sawRsp);
    int t;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqUncached = unc; reqAddr = a; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    sawRsp = 1'b0;
    rd = '0;
    t = 0;
    while (t < 2000) begin
      if (op[1] && rspValid) sawRsp = 1'b1;
      if (!op[1] && rspValid) begin sawRsp = 1'b1; rd = rspRdata; break; end
      if (op[1] && flushDone) begin rd = 32'd1; break; end
      @(negedge clk);
      t++;
    end
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic        unc;
    logic [13:0] addr;
    logic [31:0] wdata;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{2'd0, 1'b0, 14'h010, 32'h0,        32'hA5A50010},
    '{2'd1, 1'b0, 14'h010, 32'h11111111, 32'h0},
    '{2'd0, 1'b0, 14'h010, 32'h0,        32'h11111111},
    '{2'd0, 1'b1, 14'h010, 32'h0,        32'h11111111},
    '{2'd1, 1'b1, 14'h020, 32'h22222222, 32'h0},
    '{2'd0, 1'b0, 14'h020, 32'h0,        32'h22222222},
    '{2'd0, 1'b0, 14'h210, 32'h0,        32'hA5A50210},
    '{2'd0, 1'b0, 14'h410, 32'h0,        32'hA5A50410},
    '{2'd0, 1'b0, 14'h610, 32'h0,        32'hA5A50610},
    '{2'd0, 1'b0, 14'h810, 32'h0,        32'hA5A50810}
  };

  initial begin
    logic [31:0] rd;
    logic        saw;
    int          wrBefore;
    fork
      begin : main
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 reset ready", {31'd0, reqReady}, 32'd1);
        check("R10 reset outputs", {29'd0, rspValid, flushDone, memReq}, 32'd0);
        rstN = 1'b1;
        // R1 R2 R6 R5 table walk
        for (int i = 0; i < 10; i++) begin
          access(VECS[i].op, VECS[i].unc, VECS[i].addr, VECS[i].wdata, rd, saw);
          check("R1 response seen", {31'd0, saw}, 32'd1);
          if (VECS[i].op == 2'd0) check("R2 R6 table read data", rd, VECS[i].exp);
        end
        check("R5 dirty victim written back", rdMem(14'h010), 32'h11111111);
        // R5 LRU order: 410 is oldest after touching 210
        access(2'd0, 1'b0, 14'h210, 0, rd, saw);
        access(2'd0, 1'b0, 14'hA10, 0, rd, saw);
        check("R5 fill a10", rd, 32'hA5A50A10);
        memStore[14'h410] = 32'h77777777;
        access(2'd0, 1'b0, 14'h410, 0, rd, saw);
        check("R5 lru way evicted", rd, 32'h77777777);
        memStore[14'h210] = 32'h88888888;
        access(2'd0, 1'b0, 14'h210, 0, rd, saw);
        check("R4 R9 recent way kept", rd, 32'hA5A50210);
        // R3 write hit makes no memory write
        wrBefore = memWrites;
        access(2'd1, 1'b0, 14'h810, 32'h99999999, rd, saw);
        repeat (6) @(negedge clk);
        check("R3 no memory write on hit", memWrites - wrBefore, 0);
        access(2'd0, 1'b0, 14'h810, 0, rd, saw);
        check("R2 store then fetch", rd, 32'h99999999);
        // R6 uncached read miss does not allocate
        access(2'd0, 1'b1, 14'h040, 0, rd, saw);
        check("R6 uncached miss data", rd, 32'hA5A50040);
        memStore[14'h040] = 32'h34343434;
        access(2'd0, 1'b0, 14'h040, 0, rd, saw);
        check("R6 uncached miss not allocated", rd, 32'h34343434);
        // R8 flush page 0
        access(2'd1, 1'b0, 14'h030, 32'h33333333, rd, saw);
        access(2'd1, 1'b0, 14'h230, 32'h44444444, rd, saw);
        @(negedge clk);
        reqValid = 1'b1; reqOp = 2'd3; reqAddr = 14'h000;
        @(negedge clk);
        reqValid = 1'b0;
        check("R10 busy during flush", {31'd0, reqReady}, 32'd0);
        saw = 1'b0;
        for (int t = 0; t < 2000 && !flushDone; t++) begin
          if (rspValid) saw = 1'b1;
          @(negedge clk);
        end
        check("R8 flush page done", {31'd0, flushDone}, 32'd1);
        check("R10 no rsp for flush", {31'd0, saw}, 32'd0);
        check("R8 page line written", rdMem(14'h030), 32'h33333333);
        check("R8 other page untouched", rdMem(14'h230), 32'hA5A50230);
        memStore[14'h230] = 32'h55555555;
        access(2'd0, 1'b0, 14'h230, 0, rd, saw);
        check("R9 no snoop", rd, 32'h44444444);
        memStore[14'h030] = 32'h66666666;
        access(2'd0, 1'b0, 14'h030, 0, rd, saw);
        check("R8 page line invalidated", rd, 32'h66666666);
        // R7 flush all
        access(2'd2, 1'b0, 14'h000, 0, rd, saw);
        check("R7 flush all done", rd, 32'd1);
        check("R10 no rsp for flush all", {31'd0, saw}, 32'd0);
        check("R7 dirty 230 written", rdMem(14'h230), 32'h44444444);
        check("R7 dirty 810 written", rdMem(14'h810), 32'h99999999);
        memStore[14'h210] = 32'h12121212;
        access(2'd0, 1'b0, 14'h210, 0, rd, saw);
        check("R7 all invalidated", rd, 32'h12121212);
      end
      begin : watchdog
        wait (cycles >= 150000);
      end
    join_any
    if (cycles >= 150000) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog actual %0d expected below 150000", cycles);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule